// File: doc/BRIEF.md
# Power-Fail Write-Protect Supervisor

This block sits between a host and a battery-backed byte-wide memory and decides, every clock, whether the host's strobes may reach the array. Two comparator flags arrive from the analog side: one says the supply is below the deselect threshold, the other says it is below the battery switchover threshold. Both are resynchronized to the block clock. From them a four-state sequencer tracks the supply: normal operation, deselect, battery backup, and a timed recovery that keeps the memory locked after the supply returns.

In the normal state the host chip-enable, output-enable and write-enable strobes (all active low) are passed to gated internal enables and an output-drive enable. In every other state the memory is write-protected, deselected and its outputs are kept at high impedance, whatever the host does. The battery-select output follows the switchover flag, and the state is reported on a 2-bit status port. The recovery lockout is counted in clock cycles set by a parameter (2 ms at 125 MHz by default). Any new power-fail indication during recovery restarts the lockout.

Top module: `pfail_guard`

## Requirements
- R1: During and after reset, with no flag raised, the status is 00 (normal), battery select is 0 and write protect is 0.
- R2: In the normal state with host chip enable high, the internal chip enable and write enable are high (inactive) and output drive is 0, whatever the other strobes are.
- R3: In the normal state with chip enable low and write enable low, the internal write enable is low and output drive is 0, whatever output enable is.
- R4: In the normal state with chip enable low, output enable low and write enable high, output drive is 1 and the internal write enable is high.
- R5: In the normal state with chip enable low and both output enable and write enable high, the internal chip enable is low and output drive is 0.
- R6: When the below-deselect flag is raised, the status becomes 01 (deselect) and write protect 1. Outside the normal state the internal chip enable and write enable stay high and output drive stays 0 for every host strobe pattern.
- R7: When the below-switchover flag is raised, the status becomes 10 (battery) and battery select 1. This holds also when the below-deselect flag is low, because the switchover flag alone counts as below-deselect.
- R8: When the switchover flag clears, battery select returns to 0. The status moves to 01 if the deselect flag is still high, and to 11 (recovery) otherwise.
- R9: Once both flags are low, the status stays 11 with write protect 1 for exactly REC_CYCLES clock cycles, then returns to 00 with write protect 0.
- R10: A flag raised during recovery ends recovery. After the flags clear again, the full REC_CYCLES lockout is counted anew.
- R11: Each flag passes through a two-flop synchronizer. A flag change driven before a clock edge shows on the status after the third such edge, and not after the second.
- R12: A write in progress is cut off in the same cycle the status leaves 00. The internal write enable goes high together with the status change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup_low_a | input | 1 | Asynchronous flag: supply below deselect threshold |
| sup_crit_a | input | 1 | Asynchronous flag: supply below battery switchover threshold |
| host_ce_n | input | 1 | Host chip enable, active low |
| host_oe_n | input | 1 | Host output enable, active low |
| host_we_n | input | 1 | Host write enable, active low |
| mem_ce_n | output | 1 | Gated chip enable to the array, active low |
| mem_we_n | output | 1 | Gated write enable to the array, active low |
| out_drive | output | 1 | Enables the data output drivers |
| bat_sel | output | 1 | Selects the battery as memory supply |
| wr_prot | output | 1 | Memory is write-protected |
| pstate | output | 2 | Supply state: 00 normal, 01 deselect, 10 battery, 11 recovery |

## Verification
The strobe gating is tried with all eight combinations of chip, output and write enable in the normal state. This tells deselect, write, read and active-idle apart, and shows that output enable is a don't-care during writes. The supply sequence is tried as a deselect-only dip, a dip that deepens into battery mode and climbs back through deselect, and a switchover flag raised alone from normal. Each shows a different path into and out of the battery state. Recovery is run once to completion and once interrupted by a fresh dip, which separates a restarted lockout from a resumed one. A write held active across the onset of a dip, sampled one edge before and at the status change, checks the synchronizer latency and the same-cycle cut-off.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

    typedef enum logic [1:0] {
        PS_NORM  = 2'b00,
        PS_DESEL = 2'b01,
        PS_BATT  = 2'b10,
        PS_RECOV = 2'b11
    } pstate_e;

endpackage

// File: rtl/pfg_sync.sv
module pfg_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    genvar b;
    generate
        for (b = 0; b < W; b++) begin : g_bit
            logic [STAGES-1:0] chain_d, chain_q;

            always_comb begin
                chain_d = {chain_q[STAGES-2:0], din[b]};
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= chain_d;
            end

            assign dout[b] = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/pfg_seq.sv
module pfg_seq
    import pfg_pkg::*;
#(
    parameter int REC_CYCLES = 250000
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    low_s,
    input  logic    crit_s,
    output pstate_e state,
    output logic    bat_q,
    output logic    prot_q
);

    localparam int CW = (REC_CYCLES > 2) ? $clog2(REC_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(REC_CYCLES - 1);

    typedef struct packed {
        pstate_e       st;
        logic [CW-1:0] cnt;
        logic          bat;
        logic          prot;
    } seq_t;

    seq_t r_d, r_q;
    logic fail;

    always_comb begin
        r_d  = r_q;
        // the switchover flag alone also means the supply is low
        fail = low_s | crit_s;
        unique case (r_q.st)
            PS_NORM: begin
                if (crit_s)    r_d.st = PS_BATT;
                else if (fail) r_d.st = PS_DESEL;
            end
            PS_DESEL: begin
                if (crit_s) begin
                    r_d.st = PS_BATT;
                end else if (!fail) begin
                    r_d.st  = PS_RECOV;
                    r_d.cnt = '0;
                end
            end
            PS_BATT: begin
                if (!crit_s) begin
                    if (fail) begin
                        r_d.st = PS_DESEL;
                    end else begin
                        r_d.st  = PS_RECOV;
                        r_d.cnt = '0;
                    end
                end
            end
            PS_RECOV: begin
                if (crit_s) begin
                    r_d.st = PS_BATT;
                end else if (fail) begin
                    r_d.st = PS_DESEL;
                end else if (r_q.cnt == LAST) begin
                    r_d.st = PS_NORM;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: r_d.st = PS_DESEL;
        endcase
        r_d.bat  = (r_d.st == PS_BATT);
        r_d.prot = (r_d.st != PS_NORM);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= PS_NORM;
            r_q.cnt  <= '0;
            r_q.bat  <= 1'b0;
            r_q.prot <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state  = r_q.st;
    assign bat_q  = r_q.bat;
    assign prot_q = r_q.prot;

endmodule

// File: rtl/pfg_gate.sv
module pfg_gate
    import pfg_pkg::*;
(
    input  pstate_e state,
    input  logic    host_ce_n,
    input  logic    host_oe_n,
    input  logic    host_we_n,
    output logic    mem_ce_n,
    output logic    mem_we_n,
    output logic    out_drive
);

    logic pass;
    logic sel;

    always_comb begin
        pass      = (state == PS_NORM);
        sel       = pass & ~host_ce_n;
        mem_ce_n  = ~sel;
        mem_we_n  = ~(sel & ~host_we_n);
        out_drive = sel & ~host_oe_n & host_we_n;
    end

endmodule

// File: rtl/pfail_guard.sv
module pfail_guard
    import pfg_pkg::*;
#(
    parameter int REC_CYCLES  = 250000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sup_low_a,
    input  logic       sup_crit_a,
    input  logic       host_ce_n,
    input  logic       host_oe_n,
    input  logic       host_we_n,
    output logic       mem_ce_n,
    output logic       mem_we_n,
    output logic       out_drive,
    output logic       bat_sel,
    output logic       wr_prot,
    output logic [1:0] pstate
);

    logic [1:0] flags_s;
    pstate_e    st;

    pfg_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sup_crit_a, sup_low_a}),
        .dout (flags_s)
    );

    pfg_seq #(.REC_CYCLES(REC_CYCLES)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .low_s (flags_s[0]),
        .crit_s(flags_s[1]),
        .state (st),
        .bat_q (bat_sel),
        .prot_q(wr_prot)
    );

    pfg_gate u_gate (
        .state    (st),
        .host_ce_n(host_ce_n),
        .host_oe_n(host_oe_n),
        .host_we_n(host_we_n),
        .mem_ce_n (mem_ce_n),
        .mem_we_n (mem_we_n),
        .out_drive(out_drive)
    );

    assign pstate = st;

endmodule

// File: rtl/pfg_chk.sv
module pfg_chk #(
    parameter int REC_CYCLES = 250000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       host_ce_n,
    input logic       host_oe_n,
    input logic       host_we_n,
    input logic       mem_ce_n,
    input logic       mem_we_n,
    input logic       out_drive,
    input logic       bat_sel,
    input logic       wr_prot,
    input logic [1:0] pstate
);

    int rec_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               rec_run <= 0;
        else if (pstate == 2'b11) rec_run <= rec_run + 1;
        else                      rec_run <= 0;
    end

    AST_PROT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_prot |-> (mem_ce_n && mem_we_n && !out_drive)); // R6

    AST_CUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate != 2'b00) |-> mem_we_n); // R12

    AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate == 2'b00 && !host_ce_n && !host_oe_n && host_we_n) |-> out_drive); // R4

    AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_we_n) |-> !out_drive); // R3

    AST_BAT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bat_sel) |-> (pstate == 2'b01 || pstate == 2'b11)); // R8

    AST_UNPROT_FROM_REC: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_prot) |-> ($past(pstate) == 2'b11)); // R9

    AST_REC_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate == 2'b00 && $past(pstate) == 2'b11) |-> (rec_run == REC_CYCLES)); // R10

endmodule

bind pfail_guard pfg_chk #(.REC_CYCLES(REC_CYCLES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .host_ce_n(host_ce_n),
    .host_oe_n(host_oe_n),
    .host_we_n(host_we_n),
    .mem_ce_n (mem_ce_n),
    .mem_we_n (mem_we_n),
    .out_drive(out_drive),
    .bat_sel  (bat_sel),
    .wr_prot  (wr_prot),
    .pstate   (pstate)
);

// File: tb/sim_pfail_guard.sv
`timescale 1ns/1ps
module sim_pfail_guard;

    localparam int REC = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sup_low_a = 1'b0, sup_crit_a = 1'b0;
    logic host_ce_n = 1'b1, host_oe_n = 1'b1, host_we_n = 1'b1;
    logic mem_ce_n, mem_we_n, out_drive, bat_sel, wr_prot;
    logic [1:0] pstate;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    pfail_guard #(.REC_CYCLES(REC)) u0 (
        .clk(clk), .rst_n(rst_n),
        .sup_low_a(sup_low_a), .sup_crit_a(sup_crit_a),
        .host_ce_n(host_ce_n), .host_oe_n(host_oe_n), .host_we_n(host_we_n),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .out_drive(out_drive),
        .bat_sel(bat_sel), .wr_prot(wr_prot), .pstate(pstate)
    );

    // {tag[3:0], ce_n, oe_n, we_n, exp mem_ce_n, exp mem_we_n, exp out_drive}
    localparam logic [9:0] TBL [8] = '{
        {4'd2, 3'b100, 3'b110},   // R2
        {4'd2, 3'b111, 3'b110},   // R2
        {4'd2, 3'b101, 3'b110},   // R2
        {4'd3, 3'b000, 3'b000},   // R3
        {4'd3, 3'b010, 3'b000},   // R3
        {4'd4, 3'b001, 3'b011},   // R4
        {4'd5, 3'b011, 3'b010},   // R5
        {4'd2, 3'b110, 3'b110}    // R2
    };

    function automatic string tname(input logic [3:0] t);
        case (t)
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic strobes(input logic [2:0] v);
        {host_ce_n, host_oe_n, host_we_n} = v;
    endtask

    initial begin
        #1500000;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1 reset state
        step(3);
        chk("R1 pstate in reset", pstate, 0);
        chk("R1 bat_sel in reset", bat_sel, 0);
        chk("R1 wr_prot in reset", wr_prot, 0);
        rst_n = 1'b1;
        step(4);
        chk("R1 pstate after reset", pstate, 0);
        chk("R1 wr_prot after reset", wr_prot, 0);

        // strobe gating table in the normal state
        for (int i = 0; i < 8; i++) begin
            strobes(TBL[i][5:3]);
            #1;
            chk({tname(TBL[i][9:6]), " mem_ce_n"}, mem_ce_n, TBL[i][2]);
            chk({tname(TBL[i][9:6]), " mem_we_n"}, mem_we_n, TBL[i][1]);
            chk({tname(TBL[i][9:6]), " out_drive"}, out_drive, TBL[i][0]);
            step(1);
        end

        // R11 / R12: write held across a dip
        strobes(3'b000);
        step(1);
        chk("R12 write active before dip", mem_we_n, 0);
        sup_low_a = 1'b1;
        step(2);
        chk("R11 status unchanged after two edges", pstate, 0);
        chk("R11 write still active after two edges", mem_we_n, 0);
        step(1);
        chk("R11 status deselect after third edge", pstate, 1);
        chk("R12 write cut with status change", mem_we_n, 1);
        chk("R6 wr_prot in deselect", wr_prot, 1);
        // R6 host patterns ignored
        for (int v = 0; v < 8; v++) begin
            strobes(3'(v));
            #1;
            chk("R6 mem_ce_n ignored", mem_ce_n, 1);
            chk("R6 out_drive ignored", out_drive, 0);
            step(1);
        end
        strobes(3'b111);

        // R7 battery from deselect
        sup_crit_a = 1'b1;
        step(3);
        chk("R7 status battery", pstate, 2);
        chk("R7 bat_sel", bat_sel, 1);
        strobes(3'b001);
        #1;
        chk("R6 no drive in battery", out_drive, 0);
        strobes(3'b111);

        // R8 switchover clears, deselect still high
        sup_crit_a = 1'b0;
        step(3);
        chk("R8 status deselect", pstate, 1);
        chk("R8 bat_sel off", bat_sel, 0);

        // R9 full recovery
        sup_low_a = 1'b0;
        step(3);
        chk("R9 status recovery", pstate, 3);
        step(REC - 1);
        chk("R9 still recovery at last cycle", pstate, 3);
        chk("R9 wr_prot held", wr_prot, 1);
        step(1);
        chk("R9 status normal after lockout", pstate, 0);
        chk("R9 wr_prot released", wr_prot, 0);

        // R10 interrupted recovery
        sup_low_a = 1'b1;
        step(3);
        sup_low_a = 1'b0;
        step(3);
        chk("R10 status recovery", pstate, 3);
        step(5);
        sup_low_a = 1'b1;
        step(3);
        chk("R10 dip ends recovery", pstate, 1);
        sup_low_a = 1'b0;
        step(3);
        chk("R10 recovery again", pstate, 3);
        step(REC - 1);
        chk("R10 full lockout counted anew", pstate, 3);
        step(1);
        chk("R10 normal after restarted lockout", pstate, 0);

        // R7 switchover flag alone, then R8 straight into recovery
        sup_crit_a = 1'b1;
        step(3);
        chk("R7 switchover alone gives battery", pstate, 2);
        chk("R7 wr_prot with switchover alone", wr_prot, 1);
        sup_crit_a = 1'b0;
        step(3);
        chk("R8 battery to recovery", pstate, 3);
        chk("R8 bat_sel off in recovery", bat_sel, 0);
        step(REC);
        chk("R9 normal after battery path", pstate, 0);
        strobes(3'b001);
        #1;
        chk("R4 read drives after recovery", out_drive, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule